// File: doc/BRIEF.md
# Multi-Lane Latency Deskew Buffer

This block sits after the deframers of several converter links, all sampled from a common clock. Each lane delivers one sample word per frame clock together with a one-cycle start-of-multiframe marker. A shared local multiframe tick marks the receiver's own multiframe boundary. For every lane the block counts the frame cycles from the tick to that lane's marker and treats the count as the lane's latency. It then delays the early lanes through a per-lane circular buffer, so that samples taken at the same instant leave the block in the same cycle. For interleaved sampling, a per-lane phase offset adds extra cycles of delay.

A controller with four states sequences the lock. ST_WAIT_REF idles until the first tick and then moves to ST_MEASURE. In ST_MEASURE, a tick that closes a window in which every enabled lane showed a marker commits the latencies and moves to ST_FILL. A tick that closes a window with a marker missing raises the miss pulse and stays in ST_MEASURE. ST_FILL waits until the largest delay has elapsed and then moves to ST_ALIGNED, where the valid flag is high. Two events in ST_FILL or ST_ALIGNED return the controller to ST_MEASURE: a tick that finds a marker missing (which also raises the miss pulse), and a tick that finds a lane latency different from the committed one.

Top module: `multi_lane_deskew`

## Requirements
- R1: While reset is low, `aln_valid` and `mark_miss` are 0 and every `aln_data` word is 0.
- R2: A lane's latency is the number of frame cycles from the tick to its marker. A marker that arrives in the same cycle as the tick has latency 0. The count restarts at every tick.
- R3: Lane i uses bits [i*SAMPLE_W +: SAMPLE_W] of `lane_data` and `aln_data`. With all offsets at 0, the output of each enabled lane after a clock edge is the word that lane presented Lmax-Li edges earlier, where Li is the lane's committed latency and Lmax is the largest Li among enabled lanes. As a result, all enabled lanes carry words sampled at the same instant.
- R4: Lane i's offset is the unsigned field `lane_phase_ofs[i*OFS_W +: OFS_W]`. It adds that many cycles of delay, so the lane's total delay is Di = Lmax-Li+Oi, limited to DEPTH-1.
- R5: If the lock is not disturbed, `aln_valid` first goes high after edge T+Dmax+1 and stays high. Here T is the tick edge that closes the first complete window after ST_MEASURE is entered, and Dmax is the largest Di among enabled lanes.
- R6: A tick that closes a window in which an enabled lane showed no marker makes `mark_miss` high for the one following cycle. It also drops `aln_valid`, and the block measures again.
- R7: A tick that finds an enabled lane's latency different from its committed value drops `aln_valid` without a miss pulse. The block relocks on the next complete window.
- R8: A lane with its `lane_en` bit low is ignored. Its markers do not change Lmax, and a missing marker on it raises no miss pulse.
- R9: Offsets are sampled only when latencies are committed. Changing them while aligned leaves the delays and the output alignment unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mf_tick | input | 1 | Local multiframe boundary pulse |
| lane_en | input | LANES | Per-lane participation enable |
| lane_marker | input | LANES | Per-lane start-of-multiframe marker |
| lane_data | input | LANES*SAMPLE_W | Deframed sample word per lane |
| lane_phase_ofs | input | LANES*OFS_W | Per-lane interleave offset in frame cycles |
| aln_data | output | LANES*SAMPLE_W | Deskewed sample word per lane |
| aln_valid | output | 1 | All enabled lanes aligned |
| mark_miss | output | 1 | One-cycle pulse: an enabled lane missed its marker |

## Verification
The properties assume that ticks are never closer than two cycles apart. They also assume that each lane's marker arrives less than one multiframe after the tick and that `lane_en` is held steady between resets. The stimulus meets these assumptions: it issues a tick every 16 cycles, keeps every latency below 16, and changes enables only together with reset. Latency and marker changes are applied one cycle after a tick, so that each window holds at most one marker per lane.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_REF = 2'd0,
        ST_MEASURE  = 2'd1,
        ST_FILL     = 2'd2,
        ST_ALIGNED  = 2'd3
    } dsk_state_t;

endpackage

// File: rtl/mf_phase_counter.sv
module mf_phase_counter #(
    parameter int MF_LEN = 16,
    parameter int LAT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mf_tick,
    output logic [LAT_W-1:0] phase
);
    localparam logic [LAT_W-1:0] LAST = LAT_W'(MF_LEN - 1);

    logic [LAT_W-1:0] cnt_q;

    // phase is the frame count since the most recent tick, valid this cycle
    always_comb begin
        if (mf_tick)
            phase = '0;
        else if (cnt_q == LAST)
            phase = cnt_q;
        else
            phase = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= phase;
    end
endmodule

// File: rtl/lane_latency_meter.sv
module lane_latency_meter #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mf_tick,
    input  logic             lane_on,
    input  logic             marker,
    input  logic [LAT_W-1:0] phase,
    output logic             seen,
    output logic [LAT_W-1:0] lat
);
    logic hit;

    assign hit = marker & lane_on;

    // A tick opens a new window; the closing window's result is read by
    // the controller in that same cycle, before these registers update.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 1'b0;
            lat  <= '0;
        end else if (mf_tick) begin
            seen <= hit;
            if (hit)
                lat <= phase;
        end else if (hit) begin
            seen <= 1'b1;
            lat  <= phase;
        end
    end
endmodule

// File: rtl/lane_delay_line.sv
module lane_delay_line #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 32,
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [DLY_W-1:0] dly,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [DLY_W-1:0] wr_ptr;
    logic [DLY_W-1:0] rd_idx;

    assign rd_idx = wr_ptr - dly;

    always_ff @(posedge clk) begin
        mem[wr_ptr] <= din;
    end

    // dout after edge k carries the word sampled at edge k-dly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            dout   <= '0;
        end else begin
            wr_ptr <= wr_ptr + 1'b1;
            if (dly == '0)
                dout <= din;
            else
                dout <= mem[rd_idx];
        end
    end
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
    import deskew_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LAT_W = 4,
    parameter int OFS_W = 3,
    parameter int DLY_W = 5,
    parameter int DEPTH = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mf_tick,
    input  logic [LANES-1:0]       lane_en,
    input  logic [LANES-1:0]       seen,
    input  logic [LANES*LAT_W-1:0] lat_flat,
    input  logic [LANES*OFS_W-1:0] ofs_flat,
    output logic [LANES*DLY_W-1:0] dly_flat,
    output logic                   aln_valid,
    output logic                   mark_miss
);
    localparam int W1    = (LAT_W > OFS_W) ? LAT_W : OFS_W;
    localparam int SUM_W = ((W1 > DLY_W) ? W1 : DLY_W) + 2;
    localparam logic [SUM_W-1:0] DLY_CAP = SUM_W'(DEPTH - 1);

    dsk_state_t       st_q, st_n;
    logic [LAT_W-1:0] lat_cur [LANES];
    logic [LAT_W-1:0] lat_cmt [LANES];
    logic [OFS_W-1:0] ofs_v   [LANES];
    logic [SUM_W-1:0] dly_sum [LANES];
    logic [DLY_W-1:0] dly_new [LANES];
    logic [DLY_W-1:0] dly_q   [LANES];
    logic [LAT_W-1:0] lat_max;
    logic [DLY_W-1:0] dly_max_new, dly_max_q;
    logic [DLY_W-1:0] fill_cnt;
    logic             missing, changed, fill_done;
    logic             commit, miss_n;

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign lat_cur[g] = lat_flat[g*LAT_W +: LAT_W];
        assign ofs_v[g]   = ofs_flat[g*OFS_W +: OFS_W];
        assign dly_flat[g*DLY_W +: DLY_W] = dly_q[g];
    end

    assign missing   = |(lane_en & ~seen);
    assign fill_done = (fill_cnt == dly_max_q);

    always_comb begin
        changed = 1'b0;
        for (int i = 0; i < LANES; i++)
            if (lane_en[i] && (lat_cur[i] != lat_cmt[i]))
                changed = 1'b1;
    end

    always_comb begin
        lat_max = '0;
        for (int i = 0; i < LANES; i++)
            if (lane_en[i] && (lat_cur[i] > lat_max))
                lat_max = lat_cur[i];
    end

    // Di = Lmax - Li + Oi, limited to the buffer reach
    always_comb begin
        dly_max_new = '0;
        for (int i = 0; i < LANES; i++) begin
            dly_sum[i] = SUM_W'(lat_max) - SUM_W'(lat_cur[i]) + SUM_W'(ofs_v[i]);
            if (!lane_en[i])
                dly_new[i] = '0;
            else if (dly_sum[i] > DLY_CAP)
                dly_new[i] = DLY_CAP[DLY_W-1:0];
            else
                dly_new[i] = dly_sum[i][DLY_W-1:0];
            if (lane_en[i] && (dly_new[i] > dly_max_new))
                dly_max_new = dly_new[i];
        end
    end

    // next state and control strobes
    always_comb begin
        st_n   = st_q;
        commit = 1'b0;
        miss_n = 1'b0;
        unique case (st_q)
            ST_WAIT_REF: begin
                if (mf_tick)
                    st_n = ST_MEASURE;
            end
            ST_MEASURE: begin
                if (mf_tick) begin
                    if (missing) begin
                        miss_n = 1'b1;
                    end else begin
                        commit = 1'b1;
                        st_n   = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (mf_tick && missing) begin
                    miss_n = 1'b1;
                    st_n   = ST_MEASURE;
                end else if (mf_tick && changed) begin
                    st_n = ST_MEASURE;
                end else if (fill_done) begin
                    st_n = ST_ALIGNED;
                end
            end
            ST_ALIGNED: begin
                if (mf_tick && missing) begin
                    miss_n = 1'b1;
                    st_n   = ST_MEASURE;
                end else if (mf_tick && changed) begin
                    st_n = ST_MEASURE;
                end
            end
            default: st_n = ST_WAIT_REF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_WAIT_REF;
        else
            st_q <= st_n;
    end

    // committed latencies, delays and fill progress
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LANES; i++) begin
                lat_cmt[i] <= '0;
                dly_q[i]   <= '0;
            end
            dly_max_q <= '0;
            fill_cnt  <= '0;
            mark_miss <= 1'b0;
        end else begin
            mark_miss <= miss_n;
            if (commit) begin
                for (int i = 0; i < LANES; i++) begin
                    lat_cmt[i] <= lat_cur[i];
                    dly_q[i]   <= dly_new[i];
                end
                dly_max_q <= dly_max_new;
                fill_cnt  <= '0;
            end else if ((st_q == ST_FILL) && !fill_done) begin
                fill_cnt <= fill_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        aln_valid = (st_q == ST_ALIGNED);
    end
endmodule

// File: rtl/multi_lane_deskew.sv
module multi_lane_deskew #(
    parameter int LANES    = 4,
    parameter int SAMPLE_W = 16,
    parameter int MF_LEN   = 16,
    parameter int DEPTH    = 32,
    parameter int OFS_W    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mf_tick,
    input  logic [LANES-1:0]          lane_en,
    input  logic [LANES-1:0]          lane_marker,
    input  logic [LANES*SAMPLE_W-1:0] lane_data,
    input  logic [LANES*OFS_W-1:0]    lane_phase_ofs,
    output logic [LANES*SAMPLE_W-1:0] aln_data,
    output logic                      aln_valid,
    output logic                      mark_miss
);
    localparam int LAT_W = $clog2(MF_LEN);
    localparam int DLY_W = $clog2(DEPTH);

    logic [LAT_W-1:0]       phase;
    logic [LANES-1:0]       seen;
    logic [LANES*LAT_W-1:0] lat_flat;
    logic [LANES*DLY_W-1:0] dly_flat;

    mf_phase_counter #(
        .MF_LEN (MF_LEN),
        .LAT_W  (LAT_W)
    ) phase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mf_tick (mf_tick),
        .phase   (phase)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_latency_meter #(
            .LAT_W (LAT_W)
        ) meter_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .mf_tick (mf_tick),
            .lane_on (lane_en[g]),
            .marker  (lane_marker[g]),
            .phase   (phase),
            .seen    (seen[g]),
            .lat     (lat_flat[g*LAT_W +: LAT_W])
        );

        lane_delay_line #(
            .WIDTH (SAMPLE_W),
            .DEPTH (DEPTH),
            .DLY_W (DLY_W)
        ) dline_i (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (lane_data[g*SAMPLE_W +: SAMPLE_W]),
            .dly   (dly_flat[g*DLY_W +: DLY_W]),
            .dout  (aln_data[g*SAMPLE_W +: SAMPLE_W])
        );
    end

    deskew_ctrl #(
        .LANES (LANES),
        .LAT_W (LAT_W),
        .OFS_W (OFS_W),
        .DLY_W (DLY_W),
        .DEPTH (DEPTH)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mf_tick   (mf_tick),
        .lane_en   (lane_en),
        .seen      (seen),
        .lat_flat  (lat_flat),
        .ofs_flat  (lane_phase_ofs),
        .dly_flat  (dly_flat),
        .aln_valid (aln_valid),
        .mark_miss (mark_miss)
    );
endmodule

// File: rtl/deskew_checker.sv
module deskew_checker #(
    parameter int LANES = 4,
    parameter int DLY_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mf_tick,
    input logic                   aln_valid,
    input logic                   mark_miss,
    input logic [LANES*DLY_W-1:0] dly_flat
);
    AST_MISS_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        mark_miss |-> !aln_valid); // R6

    AST_MISS_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        mark_miss |-> $past(mf_tick)); // R6

    AST_MISS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mark_miss |=> !mark_miss); // R6

    AST_DROP_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aln_valid) |-> $past(mf_tick)); // R7

    AST_DELAY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (aln_valid && $past(aln_valid)) |-> $stable(dly_flat)); // R9
endmodule

bind multi_lane_deskew deskew_checker #(
    .LANES (LANES),
    .DLY_W (DLY_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mf_tick   (mf_tick),
    .aln_valid (aln_valid),
    .mark_miss (mark_miss),
    .dly_flat  (dly_flat)
);

// File: tb/multi_lane_deskew_tb_top.sv
module multi_lane_deskew_tb_top;
    localparam int LANES = 4;
    localparam int SW    = 16;
    localparam int MF    = 16;
    localparam int DEPTH = 32;
    localparam int OW    = 3;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                mf_tick;
    logic [LANES-1:0]    lane_en;
    logic [LANES-1:0]    lane_marker;
    logic [LANES*SW-1:0] lane_data;
    logic [LANES*OW-1:0] lane_phase_ofs;
    logic [LANES*SW-1:0] aln_data;
    logic                aln_valid;
    logic                mark_miss;

    always #4 clk = ~clk;

    multi_lane_deskew #(
        .LANES (LANES), .SAMPLE_W (SW), .MF_LEN (MF), .DEPTH (DEPTH), .OFS_W (OW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .mf_tick (mf_tick), .lane_en (lane_en),
        .lane_marker (lane_marker), .lane_data (lane_data),
        .lane_phase_ofs (lane_phase_ofs), .aln_data (aln_data),
        .aln_valid (aln_valid), .mark_miss (mark_miss)
    );

    int n = 0;
    int lat [LANES];
    int ofs_drv [LANES];
    int ofs_exp [LANES];
    bit mark_on [LANES];
    int checks = 0;
    int errors = 0;
    int miss_seen = 0;
    int n_rel = 0;

    // stimulus: edge n samples the words driven at the preceding negedge
    initial begin
        forever begin
            @(negedge clk);
            n++;
            mf_tick = ((n % MF) == 0);
            for (int i = 0; i < LANES; i++) begin
                int s;
                s = n - lat[i];
                lane_data[i*SW +: SW] = {4'(i), 12'(s)};
                lane_marker[i] = mark_on[i] && ((((s % MF) + MF) % MF) == 0);
                lane_phase_ofs[i*OW +: OW] = 3'(ofs_drv[i]);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        if (mark_miss) miss_seen++;
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lmax();
        int m = 0;
        for (int i = 0; i < LANES; i++)
            if (lane_en[i] && lat[i] > m) m = lat[i];
        return m;
    endfunction

    function automatic int dmax();
        int m = 0;
        for (int i = 0; i < LANES; i++)
            if (lane_en[i] && (lmax() - lat[i] + ofs_exp[i]) > m)
                m = lmax() - lat[i] + ofs_exp[i];
        return m;
    endfunction

    function automatic int exp_word(input int i);
        return ((i & 15) << 12) | ((n - lmax() - ofs_exp[i]) & 12'hFFF);
    endfunction

    task automatic check_lanes(input string req, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            step();
            for (int i = 0; i < LANES; i++)
                if (lane_en[i])
                    chk_eq(req, $sformatf("lane %0d word", i),
                           int'(aln_data[i*SW +: SW]), exp_word(i));
        end
    endtask

    task automatic wait_phase(input int r);
        do step(); while ((n % MF) != r);
    endtask

    task automatic wait_lock(input string req, input int exp_first);
        int k = 0;
        while (!aln_valid && k < 8*MF) begin
            step();
            k++;
        end
        chk_eq(req, "aln_valid reached", int'(aln_valid), 1);
        chk_eq(req, "first valid edge", n, exp_first);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step();
        chk_eq("R1", "aln_valid in reset", int'(aln_valid), 0);
        chk_eq("R1", "mark_miss in reset", int'(mark_miss), 0);
        chk_eq("R1", "aln_data in reset", int'(aln_data == '0), 1);
        for (int i = 0; i < LANES; i++) ofs_exp[i] = ofs_drv[i];
        rst_n = 1'b1;
        n_rel = n;
    endtask

    function automatic int first_after_reset();
        return ((n_rel / MF) + 1) * MF + MF + dmax() + 1;
    endfunction

    task automatic t_sync();
        lat = '{2, 5, 9, 0};
        ofs_drv = '{0, 0, 0, 0};
        lane_en = 4'hF;
        apply_reset();
        wait_lock("R5", first_after_reset());
        check_lanes("R3", 6);
        check_lanes("R2", 2);
    endtask

    task automatic t_interleave();
        ofs_drv = '{0, 1, 2, 3};
        apply_reset();
        wait_lock("R5", first_after_reset());
        check_lanes("R4", 6);
    endtask

    task automatic t_ofs_ignored();
        ofs_drv = '{0, 0, 0, 0};
        for (int i = 0; i < 2*MF; i++) step();
        chk_eq("R9", "aln_valid after ofs change", int'(aln_valid), 1);
        check_lanes("R9", 4);
    endtask

    task automatic t_lat_change();
        int m0, t_drop;
        m0 = miss_seen;
        wait_phase(1);
        lat[2] = 11;
        wait_phase(0);
        t_drop = n;
        chk_eq("R7", "aln_valid after latency change", int'(aln_valid), 0);
        chk_eq("R7", "no miss pulse", miss_seen, m0);
        for (int i = 0; i < LANES; i++) ofs_exp[i] = ofs_drv[i];
        wait_lock("R7", t_drop + MF + dmax() + 1);
        check_lanes("R7", 4);
    endtask

    task automatic t_missing();
        int m0, t_drop;
        m0 = miss_seen;
        wait_phase(1);
        mark_on[1] = 1'b0;
        wait_phase(0);
        t_drop = n;
        chk_eq("R6", "mark_miss at window close", int'(mark_miss), 1);
        chk_eq("R6", "aln_valid at window close", int'(aln_valid), 0);
        step();
        chk_eq("R6", "mark_miss one cycle", int'(mark_miss), 0);
        chk_eq("R6", "miss pulses", miss_seen, m0 + 1);
        wait_phase(1);
        mark_on[1] = 1'b1;
        wait_lock("R6", t_drop + 2*MF + dmax() + 1);
        check_lanes("R6", 3);
    endtask

    task automatic t_disabled();
        int m0;
        lat = '{2, 5, 9, 14};
        ofs_drv = '{0, 0, 0, 0};
        lane_en = 4'b0111;
        apply_reset();
        wait_lock("R8", first_after_reset());
        check_lanes("R8", 4);
        m0 = miss_seen;
        mark_on[3] = 1'b0;
        for (int i = 0; i < 3*MF; i++) step();
        chk_eq("R8", "no miss on disabled lane", miss_seen, m0);
        chk_eq("R8", "aln_valid held", int'(aln_valid), 1);
        check_lanes("R8", 2);
    endtask

    initial begin
        rst_n = 1'b0;
        mf_tick = 1'b0;
        lane_en = 4'hF;
        lane_marker = '0;
        lane_data = '0;
        lane_phase_ofs = '0;
        for (int i = 0; i < LANES; i++) begin
            lat[i] = 0;
            ofs_drv[i] = 0;
            ofs_exp[i] = 0;
            mark_on[i] = 1'b1;
        end
        t_sync();
        t_interleave();
        t_ofs_ignored();
        t_lat_change();
        t_missing();
        t_disabled();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog all actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule